// File: doc/BRIEF.md
# Latched Host Wakeup Output Controller

This block decides when to switch on the pull-up of a host-enable pin. That pin turns on the supply of a powered-down microcontroller. In the low-power modes SLEEP and VALIDATE, any one of six critical fault flags triggers it. In ACTIVE mode only a single-cycle software strobe triggers it. No fault mask is applied to this path. The six fault flags always act in the low-power modes.

Once triggered, the pull-up stays on through every mode change. It drops only on power-on reset or while the block is disarmed. A two-bit disarm field equal to 2'b11 blocks every trigger and releases the pin. Each activation also sets a sticky fault bit. Software clears that bit by disarming and then writing a system-reset strobe, and re-arms the block by writing 2'b00. A status bit reports the sensed pin level after synchronisation.

Top module: `host_wake_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), `wake_oe`, `wake_flt` and `wake_stat` are all 0.
- R2: With the block armed and `pwr_mode` equal to SLEEP (2'b01) or VALIDATE (2'b10), any single high bit of `crit_flt` makes `wake_oe` go high one clock later. The `crit_flt` bits are: bit0 tone detect, bit1 heartbeat fail, bit2 heartbeat too fast, bit3 always-on switch fail, bit4 factory CRC error, bit5 configuration monitor error.
- R3: `crit_flt` never triggers in ACTIVE (2'b00) or SHUTDOWN (2'b11), and `wake_go` never triggers outside ACTIVE.
- R4: With the block armed and in ACTIVE mode, a one-cycle `wake_go` pulse makes `wake_oe` high one clock later.
- R5: Once high, `wake_oe` stays high across mode changes and after the fault inputs fall, for as long as the block stays armed.
- R6: While `dis_field` is 2'b11, no trigger sets `wake_oe`, and a high `wake_oe` falls one clock later.
- R7: `dis_field` values 2'b00, 2'b01 and 2'b10 all leave the block armed.
- R8: Every low-to-high transition of `wake_oe` sets `wake_flt` in the same cycle.
- R9: A `sysrst_wr` pulse while `dis_field` is 2'b11 clears `wake_flt` one clock later. A pulse while armed leaves `wake_flt` and `wake_oe` unchanged.
- R10: `wake_stat` follows `pin_sense` with a latency of SYNC_STAGES clocks (default 2).
- R11: After a clear, writing 2'b00 to `dis_field` re-arms the block, and a later trigger sets `wake_oe` and `wake_flt` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset (stands for battery removal) |
| pwr_mode | input | 2 | Power mode: 00 ACTIVE, 01 SLEEP, 10 VALIDATE, 11 SHUTDOWN |
| crit_flt | input | 6 | Level-sensitive critical fault flags |
| wake_go | input | 1 | Single-cycle software trigger strobe |
| dis_field | input | 2 | Disarm field; 2'b11 disarms |
| sysrst_wr | input | 1 | Single-cycle system-reset write strobe |
| pin_sense | input | 1 | Comparator output: pin above detection threshold |
| wake_oe | output | 1 | Pull-up output enable (0 = high impedance) |
| wake_flt | output | 1 | Sticky activation fault bit |
| wake_stat | output | 1 | Synchronised sensed pin level |

## Verification
A trigger, a disarm and a clear each reach `wake_oe` or `wake_flt` through one register, so they are due one clock after the edge that samples the stimulus. `wake_stat` is due SYNC_STAGES clocks after `pin_sense` changes. The bench drives inputs on the falling edge and samples on the next falling edge, one rising edge later. For the status path it checks both one cycle early, when the old value must still show, and at the due cycle.

// File: rtl/host_wake_pkg.sv
package host_wake_pkg;
  localparam int unsigned NUM_FLT = 6;

  typedef enum logic [1:0] {
    PM_ACTIVE   = 2'b00,
    PM_SLEEP    = 2'b01,
    PM_VALIDATE = 2'b10,
    PM_SHUTDOWN = 2'b11
  } pmode_e;

  localparam logic [1:0] DIS_OFF = 2'b11;
endpackage

// File: rtl/host_wake_sync.sv
module host_wake_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_in;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/host_wake_trig.sv
module host_wake_trig
  import host_wake_pkg::*;
#(
  parameter int unsigned NFLT = NUM_FLT
) (
  input  logic [1:0]      mode,
  input  logic [NFLT-1:0] flt,
  input  logic            go,
  input  logic [1:0]      dis,
  output logic            armed,
  output logic            fire
);
  logic quiet_mode;
  logic flt_any;
  logic flt_hit;
  logic go_hit;

  always_comb begin
    armed      = (dis != DIS_OFF);
    quiet_mode = (mode == PM_SLEEP) || (mode == PM_VALIDATE);
    flt_any    = |flt;
    flt_hit    = quiet_mode && flt_any;
    go_hit     = (mode == PM_ACTIVE) && go;
    fire       = armed && (flt_hit || go_hit);
  end
endmodule

// File: rtl/host_wake_latch.sv
module host_wake_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic fire,
  input  logic clr_wr,
  output logic drive_q,
  output logic sticky_q
);
  logic drive_d;
  logic sticky_d;
  logic activate;
  logic clear_ok;

  always_comb begin
    activate = fire && !drive_q;
    clear_ok = clr_wr && !armed;
    drive_d  = armed ? (drive_q || fire) : 1'b0;
    if (activate)      sticky_d = 1'b1;
    else if (clear_ok) sticky_d = 1'b0;
    else               sticky_d = sticky_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q  <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      drive_q  <= drive_d;
      sticky_q <= sticky_d;
    end
  end
endmodule

// File: rtl/host_wake_ctrl.sv
module host_wake_ctrl
  import host_wake_pkg::*;
#(
  parameter int unsigned NFLT        = NUM_FLT,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      pwr_mode,
  input  logic [NFLT-1:0] crit_flt,
  input  logic            wake_go,
  input  logic [1:0]      dis_field,
  input  logic            sysrst_wr,
  input  logic            pin_sense,
  output logic            wake_oe,
  output logic            wake_flt,
  output logic            wake_stat
);
  logic armed;
  logic fire;

  host_wake_trig #(.NFLT(NFLT)) u_trig (
    .mode  (pwr_mode),
    .flt   (crit_flt),
    .go    (wake_go),
    .dis   (dis_field),
    .armed (armed),
    .fire  (fire)
  );

  host_wake_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (armed),
    .fire     (fire),
    .clr_wr   (sysrst_wr),
    .drive_q  (wake_oe),
    .sticky_q (wake_flt)
  );

  host_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_sense),
    .q_out (wake_stat)
  );
endmodule

// File: rtl/host_wake_chk.sv
module host_wake_chk #(
  parameter int unsigned NFLT = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      pwr_mode,
  input logic [NFLT-1:0] crit_flt,
  input logic            wake_go,
  input logic [1:0]      dis_field,
  input logic            sysrst_wr,
  input logic            wake_oe,
  input logic            wake_flt
);
  assert_quiet_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_field != 2'b11 && (pwr_mode == 2'b01 || pwr_mode == 2'b10) && |crit_flt) |=> wake_oe);

  assert_no_fault_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_oe && (pwr_mode == 2'b00 || pwr_mode == 2'b11) && !wake_go) |=> !wake_oe);

  assert_go_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_field != 2'b11 && pwr_mode == 2'b00 && wake_go) |=> wake_oe);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_oe && dis_field != 2'b11) |=> wake_oe);

  assert_disarm_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_field == 2'b11) |=> !wake_oe);

  assert_sticky_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_oe) |-> wake_flt);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sysrst_wr && dis_field == 2'b11) |=> !wake_flt);

  assert_armed_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sysrst_wr && dis_field != 2'b11 && wake_flt) |=> wake_flt);
endmodule

bind host_wake_ctrl host_wake_chk #(.NFLT(NFLT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_mode  (pwr_mode),
  .crit_flt  (crit_flt),
  .wake_go   (wake_go),
  .dis_field (dis_field),
  .sysrst_wr (sysrst_wr),
  .wake_oe   (wake_oe),
  .wake_flt  (wake_flt)
);

// File: tb/sim_host_wake_ctrl.sv
module sim_host_wake_ctrl;
  logic       clk;
  logic       rst_n;
  logic [1:0] pwr_mode;
  logic [5:0] crit_flt;
  logic       wake_go;
  logic [1:0] dis_field;
  logic       sysrst_wr;
  logic       pin_sense;
  logic       wake_oe;
  logic       wake_flt;
  logic       wake_stat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  host_wake_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .crit_flt(crit_flt),
    .wake_go(wake_go), .dis_field(dis_field), .sysrst_wr(sysrst_wr),
    .pin_sense(pin_sense), .wake_oe(wake_oe), .wake_flt(wake_flt),
    .wake_stat(wake_stat)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {req[17:14], mode[13:12], flt[11:6], go[5], dis[4:3], rst[2], exp_oe[1], exp_flt[0]}
  localparam int NV = 19;
  localparam logic [17:0] VEC [NV] = '{
    {4'd3,  2'b00, 6'h3F, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0}, // R3 active ignores faults
    {4'd3,  2'b11, 6'h3F, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0}, // R3 shutdown ignores faults
    {4'd3,  2'b01, 6'h00, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0}, // R3 go ignored in sleep
    {4'd2,  2'b01, 6'h01, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1}, // R2 R8 tone fault in sleep
    {4'd5,  2'b00, 6'h00, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1}, // R5 held in active
    {4'd5,  2'b11, 6'h00, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1}, // R5 held in shutdown
    {4'd9,  2'b11, 6'h00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1}, // R9 armed reset no effect
    {4'd6,  2'b11, 6'h00, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1}, // R6 disarm releases
    {4'd6,  2'b01, 6'h3F, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1}, // R6 disarmed blocks faults
    {4'd9,  2'b01, 6'h00, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0}, // R9 clear while disarmed
    {4'd11, 2'b10, 6'h20, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1}, // R11 R2 rearm, validate
    {4'd6,  2'b10, 6'h00, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1}, // R6
    {4'd9,  2'b10, 6'h00, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0}, // R9
    {4'd6,  2'b00, 6'h00, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0}, // R6 go blocked when disarmed
    {4'd7,  2'b00, 6'h00, 1'b1, 2'b01, 1'b0, 1'b1, 1'b1}, // R7 R4 armed by 01
    {4'd6,  2'b00, 6'h00, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1}, // R6
    {4'd9,  2'b00, 6'h00, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0}, // R9
    {4'd7,  2'b01, 6'h08, 1'b0, 2'b10, 1'b0, 1'b1, 1'b1}, // R7 armed by 10
    {4'd5,  2'b01, 6'h00, 1'b0, 2'b10, 1'b0, 1'b1, 1'b1}  // R5 fault gone, still held
  };

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [5:0] f, input logic g,
                      input logic [1:0] d, input logic r);
    pwr_mode = m; crit_flt = f; wake_go = g; dis_field = d; sysrst_wr = r;
    @(posedge clk);
    @(negedge clk);
    wake_go = 1'b0; sysrst_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; pwr_mode = 2'b00; crit_flt = '0; wake_go = 1'b0;
    dis_field = 2'b00; sysrst_wr = 1'b0; pin_sense = 1'b0;
    repeat (3) @(negedge clk);
    check(wake_oe, 1'b0, "R1 oe in reset");
    check(wake_flt, 1'b0, "R1 flt in reset");
    check(wake_stat, 1'b0, "R1 stat in reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      step(v[13:12], v[11:6], v[5], v[4:3], v[2]);
      check(wake_oe, v[1], $sformatf("R%0d vec %0d oe", v[17:14], i));
      check(wake_flt, v[0], $sformatf("R%0d vec %0d flt", v[17:14], i));
    end

    // R2: each fault bit alone, alternating SLEEP and VALIDATE
    for (int b = 0; b < 6; b++) begin
      step(2'b01, 6'h00, 1'b0, 2'b11, 1'b1);
      step(2'b01, 6'h00, 1'b0, 2'b00, 1'b0);
      check(wake_oe, 1'b0, $sformatf("R2 idle before bit %0d", b));
      step((b % 2 == 0) ? 2'b01 : 2'b10, 6'(1 << b), 1'b0, 2'b00, 1'b0);
      check(wake_oe, 1'b1, $sformatf("R2 fault bit %0d oe", b));
      check(wake_flt, 1'b1, $sformatf("R8 fault bit %0d flt", b));
    end

    // R10: status latency of two clocks
    pin_sense = 1'b1;
    @(posedge clk); @(negedge clk);
    check(wake_stat, 1'b0, "R10 stat one cycle early");
    @(posedge clk); @(negedge clk);
    check(wake_stat, 1'b1, "R10 stat due");
    pin_sense = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check(wake_stat, 1'b0, "R10 stat falls");

    // R1: power-on reset clears latched output and sticky bit
    check(wake_oe, 1'b1, "R5 latched before reset");
    rst_n = 1'b0;
    @(negedge clk);
    check(wake_oe, 1'b0, "R1 oe after power loss");
    check(wake_flt, 1'b0, "R1 flt after power loss");
    rst_n = 1'b1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule